// File: doc/BRIEF.md
# Alternate-Byte Peripheral Move Sequencer

This block carries out a byte-serial register move between a data register and an 8-bit peripheral that sits on one byte lane of a 16-bit bus. The caller presents an opcode word, the value of the selected data register, the value of the selected address register and a 16-bit displacement, then pulses `start`. The block decodes the direction and the size, works out the start address, and issues one byte request per transfer on a request/acknowledge memory port. Successive transfers step the address by two, so every byte lands on the same lane.

Stores split the register into big-endian bytes when the move is launched. Loads gather the bytes and hand the assembled register value back with a one-cycle write enable once every read has finished. One idle bus cycle comes before the transfers and one after them. These stand in for the prefetch slots of the surrounding processor. The register numbers decoded from the opcode are also presented combinationally, so the caller can fetch the two operand values.

Top module: `alt_byte_mover`

## Requirements
- R1: The opcode is legal only when `opcode & 16'hF1F8` equals 16'h0108 (load word), 16'h0148 (load long), 16'h0188 (store word) or 16'h01C8 (store long). A start with any other opcode raises `illegal` for one cycle and issues no memory request.
- R2: `dreg_num` shows opcode bits 11:9 and `areg_num` shows opcode bits 2:0. A load writes back to the data register numbered by opcode bits 11:9, which appears on `rf_idx`.
- R3: The first transfer uses address `areg_val` plus `disp`, with `disp` sign-extended to the address width.
- R4: A word move makes exactly 2 byte transfers and a long move makes exactly 4. Each transfer address is 2 above the one before it.
- R5: A long store sends data register bits 31:24, then 23:16, then 15:8, then 7:0.
- R6: A word store sends only bits 15:8 and then bits 7:0 of the data register.
- R7: A long load returns the four bytes read, with the first read in bits 31:24. A word load returns the two bytes read in bits 15:0, with the first read in bits 15:8, and keeps bits 31:16 of `dreg_val` as they were at start.
- R8: `mem_req` stays low in the first busy cycle after a start, and also in the cycle that follows the final acknowledge.
- R9: A request holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ack` is seen.
- R10: `done` is high for exactly one cycle, the cycle right after the final acknowledge. `rf_we` is high in that same cycle for loads and never for stores.
- R11: A `start` that arrives while the block is busy is ignored. The move in progress completes with its original operands and target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches a move when idle |
| opcode | input | 16 | Instruction word |
| dreg_num | output | 3 | Data register number decoded from `opcode` |
| areg_num | output | 3 | Address register number decoded from `opcode` |
| dreg_val | input | 32 | Current value of the selected data register |
| areg_val | input | ADDR_W | Current value of the selected address register |
| disp | input | 16 | Signed displacement |
| busy | output | 1 | A move is in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse for an unmatched opcode |
| mem_req | output | 1 | Byte transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Transfer accepted or completed |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| rf_we | output | 1 | Register write enable for loads |
| rf_idx | output | 3 | Register number to write |
| rf_wdata | output | 32 | Value to write |

## Verification
The hardest case to reach from the ports is a word load that must keep the upper half of the register. It only goes wrong when bits 31:16 of `dreg_val` differ from what the accumulated bytes would leave there, and when read data arrives after stalls. The stimulus therefore uses random full 32-bit register values and a memory model that inserts random wait cycles before each acknowledge. A second case is a `start` pulsed during the pre-transfer idle slot with different operands. A directed test fires that pulse at exactly that cycle and checks that the write-back still uses the first register number and the first data.

// File: rtl/mover_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the alternate-byte move sequencer.
// Assumes 8-bit transfers and a 32-bit register file.
package mover_pkg;

    localparam int DATA_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 2;
    localparam int LONG_BYTES = 4;

    localparam logic [15:0] OPC_MASK    = 16'hF1F8;
    localparam logic [15:0] OPC_LOAD_W  = 16'h0108;
    localparam logic [15:0] OPC_LOAD_L  = 16'h0148;
    localparam logic [15:0] OPC_STORE_W = 16'h0188;
    localparam logic [15:0] OPC_STORE_L = 16'h01C8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE,
        ST_XFER,
        ST_POST
    } mv_state_e;

    typedef struct packed {
        logic       legal;
        logic       to_mem;
        logic       is_long;
        logic [2:0] dreg;
    } mv_decode_t;

endpackage

// File: rtl/mover_decode.sv
`timescale 1ns/1ps
// Opcode decoder: matches the four move patterns under one shared mask
// and pulls out direction, size and data register number.
// Purely combinational; assumes the opcode is stable while it is sampled.
module mover_decode
    import mover_pkg::*;
(
    input  logic [15:0] opcode,
    output mv_decode_t  dec
);

    // Pattern match and field extraction
    always_comb begin
        dec        = '0;
        dec.dreg   = opcode[11:9];
        unique case (opcode & OPC_MASK)
            OPC_LOAD_W:  begin dec.legal = 1'b1; dec.to_mem = 1'b0; dec.is_long = 1'b0; end
            OPC_LOAD_L:  begin dec.legal = 1'b1; dec.to_mem = 1'b0; dec.is_long = 1'b1; end
            OPC_STORE_W: begin dec.legal = 1'b1; dec.to_mem = 1'b1; dec.is_long = 1'b0; end
            OPC_STORE_L: begin dec.legal = 1'b1; dec.to_mem = 1'b1; dec.is_long = 1'b1; end
            default:     dec.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/mover_ctrl.sv
`timescale 1ns/1ps
// Sequencer control: idle slot, byte transfers, idle slot, then a done pulse.
// Latches the decoded fields at launch so that later inputs have no effect.
// Assumes mem_ack is only meaningful while a request is raised.
module mover_ctrl
    import mover_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  mv_decode_t dec,
    input  logic       mem_ack,
    output logic       launch,
    output logic       advance,
    output logic       busy,
    output logic       done,
    output logic       illegal,
    output logic       req,
    output logic       to_mem_q,
    output logic       long_q,
    output logic [2:0] dreg_q
);

    localparam int CNT_W = $clog2(LONG_BYTES);

    mv_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    // Launch, advance and last-byte conditions
    always_comb begin
        launch  = (state_q == ST_IDLE) && start && dec.legal;
        advance = (state_q == ST_XFER) && mem_ack;
        last    = (cnt_q == (long_q ? CNT_W'(LONG_BYTES - 1) : CNT_W'(WORD_BYTES - 1)));
    end

    // State, transfer count and latched operation fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            to_mem_q <= 1'b0;
            long_q   <= 1'b0;
            dreg_q   <= '0;
            illegal  <= 1'b0;
        end else begin
            illegal <= (state_q == ST_IDLE) && start && !dec.legal;
            unique case (state_q)
                ST_IDLE: if (launch) begin
                    state_q  <= ST_PRE;
                    cnt_q    <= '0;
                    to_mem_q <= dec.to_mem;
                    long_q   <= dec.is_long;
                    dreg_q   <= dec.dreg;
                end
                ST_PRE:  state_q <= ST_XFER;
                ST_XFER: if (advance) begin
                    if (last) state_q <= ST_POST;
                    else      cnt_q   <= cnt_q + 1'b1;
                end
                ST_POST: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Status and request outputs decoded from the state
    always_comb begin
        busy = (state_q != ST_IDLE);
        done = (state_q == ST_POST);
        req  = (state_q == ST_XFER);
    end

endmodule

// File: rtl/mover_datapath.sv
`timescale 1ns/1ps
// Datapath: start address, address stepping, big-endian byte split for
// stores and byte gathering for loads. Assumes ADDR_W >= 16.
module mover_datapath
    import mover_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STRIDE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              advance,
    input  logic              is_long,
    input  logic              long_q,
    input  logic [DATA_W-1:0] dreg_val,
    input  logic [ADDR_W-1:0] areg_val,
    input  logic [15:0]       disp,
    input  logic [BYTE_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] wdata,
    output logic [DATA_W-1:0] result
);

    localparam int HALF_W = DATA_W / 2;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] shift_q;
    logic [DATA_W-1:0] acc_q;
    logic [HALF_W-1:0] keep_hi_q;

    // Address, outgoing byte shifter and incoming byte accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            shift_q   <= '0;
            acc_q     <= '0;
            keep_hi_q <= '0;
        end else if (launch) begin
            addr_q    <= areg_val + {{(ADDR_W-16){disp[15]}}, disp};
            shift_q   <= is_long ? dreg_val : {dreg_val[HALF_W-1:0], {HALF_W{1'b0}}};
            acc_q     <= '0;
            keep_hi_q <= dreg_val[DATA_W-1:HALF_W];
        end else if (advance) begin
            addr_q  <= addr_q + ADDR_W'(STRIDE);
            shift_q <= {shift_q[DATA_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
            acc_q   <= {acc_q[DATA_W-BYTE_W-1:0], rdata};
        end
    end

    // Bus-facing values and the merged register result
    always_comb begin
        addr   = addr_q;
        wdata  = shift_q[DATA_W-1 -: BYTE_W];
        result = long_q ? acc_q : {keep_hi_q, acc_q[HALF_W-1:0]};
    end

endmodule

// File: rtl/alt_byte_mover.sv
`timescale 1ns/1ps
// Top of the alternate-byte move sequencer. Moves a data register to or
// from every other byte address over a request/acknowledge port.
// Assumes the caller supplies the operand values named by dreg_num and
// areg_num in the cycle that start is high.
module alt_byte_mover
    import mover_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STRIDE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       opcode,
    output logic [2:0]        dreg_num,
    output logic [2:0]        areg_num,
    input  logic [31:0]       dreg_val,
    input  logic [ADDR_W-1:0] areg_val,
    input  logic [15:0]       disp,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic              rf_we,
    output logic [2:0]        rf_idx,
    output logic [31:0]       rf_wdata
);

    mv_decode_t dec;
    logic       launch;
    logic       advance;
    logic       req;
    logic       to_mem_q;
    logic       long_q;
    logic [2:0] dreg_q;

    mover_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    mover_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dec      (dec),
        .mem_ack  (mem_ack),
        .launch   (launch),
        .advance  (advance),
        .busy     (busy),
        .done     (done),
        .illegal  (illegal),
        .req      (req),
        .to_mem_q (to_mem_q),
        .long_q   (long_q),
        .dreg_q   (dreg_q)
    );

    mover_datapath #(
        .ADDR_W (ADDR_W),
        .STRIDE (STRIDE)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .advance  (advance),
        .is_long  (dec.is_long),
        .long_q   (long_q),
        .dreg_val (dreg_val),
        .areg_val (areg_val),
        .disp     (disp),
        .rdata    (mem_rdata),
        .addr     (mem_addr),
        .wdata    (mem_wdata),
        .result   (rf_wdata)
    );

    // Port-level glue: register numbers, bus direction and write-back
    always_comb begin
        dreg_num = dec.dreg;
        areg_num = opcode[2:0];
        mem_req  = req;
        mem_we   = req && to_mem_q;
        rf_we    = done && !to_mem_q;
        rf_idx   = dreg_q;
    end

endmodule

// File: rtl/mover_checker.sv
`timescale 1ns/1ps
// Protocol checker for alt_byte_mover, attached by bind below.
// Observes ports only; assumes the synchronous active-low reset.
module mover_checker #(
    parameter int ADDR_W = 32,
    parameter int STRIDE = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              illegal,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              rf_we,
    input logic [2:0]        rf_idx
);

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (!mem_req || (mem_addr == $past(mem_addr) + ADDR_W'(STRIDE))));

    p_no_bus_illegal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_req && !busy));

    p_pre_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !mem_req);

    p_done_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_req && mem_ack) && !mem_req));

    p_rfwe_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (done && !$past(mem_we)));

    p_target_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rf_idx));

endmodule

bind alt_byte_mover mover_checker #(
    .ADDR_W (ADDR_W),
    .STRIDE (STRIDE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rf_we     (rf_we),
    .rf_idx    (rf_idx)
);

// File: tb/sim_alt_byte_mover.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases plus seeded random moves
// against a byte memory that inserts random wait cycles.
module sim_alt_byte_mover;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] opcode = '0;
    logic [2:0]  dreg_num, areg_num;
    logic [31:0] dreg_val = '0;
    logic [31:0] areg_val = '0;
    logic [15:0] disp = '0;
    logic        busy, done, illegal;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        rf_we;
    logic [2:0]  rf_idx;
    logic [31:0] rf_wdata;

    always #2.5 clk = ~clk;

    alt_byte_mover u0 (.*);

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0]  mem [0:1023];
    int          n_x;
    logic [31:0] x_addr [0:7];
    logic        x_we   [0:7];
    logic [7:0]  x_data [0:7];
    int          cyc = 0;
    int          last_ack_cyc = 0;
    int          wcnt = 0;
    int          wmax = 0;

    // Memory responder: random wait, then one-cycle ack, driven at negedge
    always @(negedge clk) begin
        cyc = cyc + 1;
        mem_ack = 1'b0;
        if (mem_req) begin
            if (wcnt > 0) wcnt = wcnt - 1;
            else begin
                mem_ack = 1'b1;
                if (n_x < 8) begin
                    x_addr[n_x] = mem_addr;
                    x_we[n_x]   = mem_we;
                    x_data[n_x] = mem_wdata;
                end
                n_x = n_x + 1;
                if (mem_we) mem[mem_addr[9:0]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[9:0]];
                last_ack_cyc = cyc;
                wcnt = $urandom_range(0, wmax);
            end
        end
    end

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [15:0] mk_op(input logic [1:0] mode, input logic [2:0] dr, input logic [2:0] ar);
        return {4'b0000, dr, 1'b1, mode, 3'b001, ar};
    endfunction

    // One move: drive, observe, compare against values worked out here
    task automatic run_op(input logic [15:0] op, input logic [31:0] dv, input logic [31:0] av,
                          input logic [15:0] dp, input bit poke);
        logic [15:0] masked = op & 16'hF1F8;
        bit legal   = (masked == 16'h0108) || (masked == 16'h0148) ||
                      (masked == 16'h0188) || (masked == 16'h01C8);
        bit to_mem  = op[7];
        bit is_long = op[6];
        int nb      = is_long ? 4 : 2;
        logic [31:0] base = av + {{16{dp[15]}}, dp};
        logic [31:0] exp_val;
        logic [31:0] src;
        bit seen = 0;
        exp_val = is_long ? 32'h0 : {dv[31:16], 16'h0};
        if (legal && !to_mem) begin
            for (int i = 0; i < nb; i++) begin
                logic [31:0] a = base + 32'(2*i);
                logic [7:0]  b = 8'($urandom);
                mem[a[9:0]] = b;
                exp_val = is_long ? {exp_val[23:0], b} : {dv[31:16], exp_val[7:0], b};
            end
        end
        src = is_long ? dv : {dv[15:0], 16'h0};
        n_x = 0;
        wcnt = $urandom_range(0, wmax);
        @(negedge clk);
        start = 1'b1; opcode = op; dreg_val = dv; areg_val = av; disp = dp;
        #1;
        check(dreg_num == op[11:9], "R2 dreg_num", 32'(dreg_num), 32'(op[11:9]));
        check(areg_num == op[2:0], "R2 areg_num", 32'(areg_num), 32'(op[2:0]));
        tick();
        if (poke) begin
            // R11: second start with different operands during the idle slot
            start = 1'b1; opcode = mk_op(~op[7:6], ~op[11:9], op[2:0]);
            dreg_val = ~dv; areg_val = av + 32'h40; disp = ~dp;
        end else start = 1'b0;
        if (!legal) begin
            check(illegal == 1'b1, "R1 illegal pulse", 32'(illegal), 32'd1);
            check(busy == 1'b0, "R1 stays idle", 32'(busy), 32'd0);
            repeat (6) tick();
            check(n_x == 0, "R1 no bus cycles", 32'(n_x), 32'd0);
            return;
        end
        check(busy == 1'b1 && mem_req == 1'b0, "R8 pre slot", {busy, mem_req}, 32'b10);
        for (int k = 0; k < 200; k++) begin
            tick();
            start = 1'b0;
            if (done) begin seen = 1; break; end
        end
        check(seen, "R10 done seen", 32'(seen), 32'd1);
        if (!seen) return;
        check(cyc == last_ack_cyc + 1, "R10 done after last ack", 32'(cyc), 32'(last_ack_cyc + 1));
        check(mem_req == 1'b0, "R8 post slot", 32'(mem_req), 32'd0);
        check(n_x == nb, "R4 transfer count", 32'(n_x), 32'(nb));
        for (int i = 0; i < nb && i < n_x; i++) begin
            logic [31:0] ea = base + 32'(2*i);
            check(x_addr[i] == ea, (i == 0) ? "R3 start address" : "R4 address step", x_addr[i], ea);
            check(x_we[i] == to_mem, "R4 direction", 32'(x_we[i]), 32'(to_mem));
            if (to_mem)
                check(x_data[i] == src[31-8*i -: 8], is_long ? "R5 long byte order" : "R6 word bytes",
                      32'(x_data[i]), 32'(src[31-8*i -: 8]));
        end
        if (to_mem) begin
            check(rf_we == 1'b0, "R10 no write-back on store", 32'(rf_we), 32'd0);
        end else begin
            check(rf_we == 1'b1, "R10 write-back on load", 32'(rf_we), 32'd1);
            check(rf_idx == op[11:9], "R2 R11 target register", 32'(rf_idx), 32'(op[11:9]));
            check(rf_wdata == exp_val, is_long ? "R7 long load" : "R7 word load", rf_wdata, exp_val);
        end
        tick();
        check(done == 1'b0 && busy == 1'b0, "R10 single done pulse", {done, busy}, 32'b00);
    endtask

    initial begin
        process::self().srandom(32'd1234);
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!busy && !done && !illegal && !mem_req && !rf_we, "R10 reset state",
              {busy, done, illegal, mem_req, rf_we}, 32'd0);
        // Directed: each mode, zero waits
        run_op(16'h01C8 | 16'h0A05, 32'hA1B2C3D4, 32'h0000_0100, 16'h0010, 0); // R5
        run_op(16'h0188 | 16'h0601, 32'hDEAD5A7E, 32'h0000_0200, 16'h0004, 0); // R6
        run_op(16'h0148 | 16'h0E07, 32'h12345678, 32'h0000_0300, 16'hFFF0, 0); // R7 negative disp
        run_op(16'h0108 | 16'h0202, 32'hCAFEF00D, 32'h0000_FFFF, 16'h0001, 0); // R7, R3 carry
        // Directed: illegal patterns
        run_op(16'h0100, 32'h1, 32'h0, 16'h0, 0);   // R1 mode field 000
        run_op(16'h1108, 32'h1, 32'h0, 16'h0, 0);   // R1 top nibble set
        run_op(16'h0110, 32'h1, 32'h0, 16'h0, 0);   // R1 mode field 010
        // Directed: start while busy, with waits
        wmax = 2;
        run_op(16'h0108 | 16'h0803, 32'h7777_1234, 32'h0000_0080, 16'h0008, 1); // R11
        run_op(16'h01C8 | 16'h0404, 32'h89ABCDEF, 32'h0000_0040, 16'h8000, 1); // R11
        // Random moves
        for (int n = 0; n < 60; n++) begin
            logic [1:0] md = 2'($urandom);
            wmax = $urandom_range(0, 3);
            run_op(mk_op(md, 3'($urandom), 3'($urandom)), $urandom, $urandom, 16'($urandom),
                   ($urandom_range(0, 3) == 0));
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule